// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a flat panel: a pixel strobe derived from the logic clock by a programmable divider, line and frame sync pulses, a data-enable window, a gated pixel-valid strobe and, for passive panels, an alternating AC-bias level. The whole geometry comes from three packed configuration words: one for the horizontal axis, one for the vertical axis, and one for the divider, AC-bias interval and sync polarity. Fetching pixels, looking up colours and moving memory are left to neighbouring logic. That logic reports back through two inputs: a starvation input and a sync-error input.

Software sets the three words while the block is idle and then raises `enable`. Each line steps through sync, back porch, active and front porch, counted in pixel strobes. The frame steps through the same four phases, counted in lines. Dropping `enable` does not cut the picture: the frame in progress runs to its end, the outputs then go idle and a done flag rises. The done flag stays up until the block is enabled again. Two sticky error flags record pixel starvation and sync loss, and both are cleared while `enable` is low.

Top module: `lcd_raster_timer`

## Requirements
- R1: Horizontal word: bits 9:0 hold active pixels minus one, bits 15:10 sync width minus one, bits 23:16 front porch minus one and bits 31:24 back porch minus one. A line lasts D×(sync+back+active+front) logic clocks, where D is the effective divider, and `hsync` is asserted for D×sync clocks of each line.
- R2: Vertical word: bits 9:0 hold active lines minus one and bits 15:10 sync lines minus one. Bits 23:16 (front porch) and 31:24 (back porch) hold the true line count, and zero is allowed. A frame lasts (sync+back+active+front) lines, and `vsync` is asserted for the sync lines.
- R3: The effective divider D is clock-word bits 7:0, raised to at least 2 when `tft_mode`=1 and to at least 3 when `tft_mode`=0. `pix_tick` pulses once every D clocks.
- R4: `de` is high only while both axes are in their active phases, which is D×active_pixels×active_lines clocks per frame. `pix_valid` pulses active_pixels×active_lines times per frame.
- R5: Both syncs are active low by default. Clock-word bit 21 set makes `hsync` active high and bit 20 set makes `vsync` active high, and this also applies to their idle level.
- R6: After `enable` falls, the current frame completes. At its end `frame_done` rises, and the syncs and `de` stay idle from then on.
- R7: `frame_done` holds while `enable` stays low and clears once the block is enabled again.
- R8: A `pix_valid` pulse while `pix_empty` is high sets `underflow`. The flag holds until `enable` is low, which clears it.
- R9: `sync_err` while running sets `sync_lost`. The flag holds until `enable` is low, which clears it. `sync_err` is ignored while idle.
- R10: In passive mode `ac_bias` toggles after every (N+1) lines, where N is clock-word bits 15:8. In TFT mode `ac_bias` stays 0.
- R11: During reset `hsync` and `vsync` are 1, and `de`, `pix_valid`, `frame_done`, `underflow`, `sync_lost` and `ac_bias` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low lets the current frame finish |
| tft_mode | input | 1 | 1 = active-matrix panel, 0 = passive panel |
| horiz_cfg | input | 32 | Packed horizontal timing word |
| vert_cfg | input | 32 | Packed vertical timing word |
| clock_cfg | input | 32 | Divider, AC-bias interval, sync polarity |
| pix_empty | input | 1 | Pixel source has no data ready |
| sync_err | input | 1 | Pixel source lost frame alignment |
| pix_tick | output | 1 | Pixel-clock strobe |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data-enable window |
| pix_valid | output | 1 | Pixel accepted this clock |
| ac_bias | output | 1 | Passive-panel bias alternation |
| frame_done | output | 1 | Stop completed after disable |
| underflow | output | 1 | Sticky starvation flag |
| sync_lost | output | 1 | Sticky sync-loss flag |

## Verification
A wrong divider count or a wrong phase counter shows up within one frame as a wrong frame period or a wrong number of sync or data-enable clocks, so each configuration is measured over one full frame between two vsync edges. A wrong stop condition shows up either as activity after `frame_done` or as `frame_done` rising before the frame has had its full length. Both are checked within a few clocks of the expected frame end. The sticky flags are checked for setting, holding, clearing and ignoring within a few clocks of the stimulus.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

   localparam int LEN_W     = 11;
   localparam int ACT_LSB   = 0;
   localparam int ACT_W     = 10;
   localparam int SYNC_LSB  = 10;
   localparam int SYNC_W    = 6;
   localparam int FRONT_LSB = 16;
   localparam int BACK_LSB  = 24;
   localparam int PORCH_W   = 8;
   localparam int CFG_W     = BACK_LSB + PORCH_W;

   localparam int DIV_LSB   = 0;
   localparam int DIV_W     = 8;
   localparam int ACB_LSB   = 8;
   localparam int ACB_W     = 8;
   localparam int POL_LSB   = 20;
   localparam int POL_W     = 6;
   localparam int POL_VS    = 0;
   localparam int POL_HS    = 1;

   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } lcdt_phase_e;

   typedef struct packed {
      logic [LEN_W-1:0] sync_len;
      logic [LEN_W-1:0] back_len;
      logic [LEN_W-1:0] act_len;
      logic [LEN_W-1:0] front_len;
   } lcdt_axis_t;

   // Active and sync fields are always stored minus one; porches only when biased.
   function automatic lcdt_axis_t unpack_axis(input logic [CFG_W-1:0] w,
                                              input logic porch_biased);
      lcdt_axis_t a;
      logic [LEN_W-1:0] bias;
      bias        = porch_biased ? LEN_W'(1) : '0;
      a.act_len   = LEN_W'(w[ACT_LSB +: ACT_W]) + LEN_W'(1);
      a.sync_len  = LEN_W'(w[SYNC_LSB +: SYNC_W]) + LEN_W'(1);
      a.front_len = LEN_W'(w[FRONT_LSB +: PORCH_W]) + bias;
      a.back_len  = LEN_W'(w[BACK_LSB +: PORCH_W]) + bias;
      return a;
   endfunction

endpackage

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv #(
   parameter int DIV_W   = 8,
   parameter int TFT_MIN = 2,
   parameter int PAS_MIN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tft,
   input  logic [DIV_W-1:0] div_field,
   output logic             stb
);
   localparam logic [DIV_W-1:0] TMIN = DIV_W'(TFT_MIN);
   localparam logic [DIV_W-1:0] PMIN = DIV_W'(PAS_MIN);

   initial begin
      assert (TFT_MIN >= 2 && PAS_MIN >= 2) else $error("divider floor below 2");
      assert (PAS_MIN < (1 << DIV_W))       else $error("divider floor exceeds field");
   end

   logic [DIV_W-1:0] floor_v;
   logic [DIV_W-1:0] eff;
   logic [DIV_W-1:0] cnt;

   always_comb begin
      floor_v = tft ? TMIN : PMIN;
      eff     = (div_field < floor_v) ? floor_v : div_field;
   end

   assign stb = run && (cnt == eff - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run || stb) cnt <= '0;
      else                 cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
   import lcdt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        step,
   input  lcdt_axis_t  len,
   output lcdt_phase_e phase,
   output logic        wrap
);
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] cur_len;
   lcdt_phase_e      nxt;
   logic             last;

   always_comb begin
      unique case (phase)
         PH_SYNC:  cur_len = len.sync_len;
         PH_BACK:  cur_len = len.back_len;
         PH_ACT:   cur_len = len.act_len;
         default:  cur_len = len.front_len;
      endcase
      // zero-length porches are skipped
      unique case (phase)
         PH_SYNC:  nxt = (len.back_len != '0) ? PH_BACK : PH_ACT;
         PH_BACK:  nxt = PH_ACT;
         PH_ACT:   nxt = (len.front_len != '0) ? PH_FRONT : PH_SYNC;
         default:  nxt = PH_SYNC;
      endcase
   end

   assign last = (cnt == cur_len - LEN_W'(1));
   assign wrap = run && step && last && (nxt == PH_SYNC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (!run) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (step) begin
         if (last) begin
            phase <= nxt;
            cnt   <= '0;
         end else begin
            cnt   <= cnt + LEN_W'(1);
         end
      end
   end
endmodule

// File: rtl/lcdt_status.sv
module lcdt_status (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic frame_end,
   input  logic starve_evt,
   input  logic lost_evt,
   output logic running,
   output logic done,
   output logic fuf,
   output logic lost
);
   logic start;
   logic stop;

   assign start = enable && !running;
   assign stop  = running && !enable && frame_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         done    <= 1'b0;
      end else if (start) begin
         running <= 1'b1;
         done    <= 1'b0;
      end else if (stop) begin
         running <= 1'b0;
         done    <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fuf  <= 1'b0;
         lost <= 1'b0;
      end else if (!enable) begin
         fuf  <= 1'b0;
         lost <= 1'b0;
      end else if (running) begin
         if (starve_evt) fuf  <= 1'b1;
         if (lost_evt)   lost <= 1'b1;
      end
   end
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
   import lcdt_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter bit OUT_REG     = 1'b1,
   parameter int TFT_DIV_MIN = 2,
   parameter int PAS_DIV_MIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tft_mode,
   input  logic [WORD_W-1:0] horiz_cfg,
   input  logic [WORD_W-1:0] vert_cfg,
   input  logic [WORD_W-1:0] clock_cfg,
   input  logic              pix_empty,
   input  logic              sync_err,
   output logic              pix_tick,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic              pix_valid,
   output logic              ac_bias,
   output logic              frame_done,
   output logic              underflow,
   output logic              sync_lost
);
   localparam int POL_HI = POL_LSB + POL_W;

   initial begin
      assert (WORD_W == CFG_W) else $error("config word width must be %0d", CFG_W);
   end

   lcdt_axis_t       h_len, v_len;
   lcdt_phase_e      h_phase, v_phase;
   logic             pix_stb, h_wrap, frame_end;
   logic             running;
   logic             hs_act, vs_act, de_raw, pv_raw;
   logic             hs_pin, vs_pin;
   logic [DIV_W-1:0] div_field;
   logic [ACB_W-1:0] acb_field;
   logic [POL_W-1:0] pol;
   logic             unused_cfg_bits;

   assign h_len     = unpack_axis(horiz_cfg, 1'b1);
   assign v_len     = unpack_axis(vert_cfg, 1'b0);
   assign div_field = clock_cfg[DIV_LSB +: DIV_W];
   assign acb_field = clock_cfg[ACB_LSB +: ACB_W];
   assign pol       = clock_cfg[POL_LSB +: POL_W];
   assign unused_cfg_bits = ^{clock_cfg[WORD_W-1:POL_HI], clock_cfg[POL_LSB-1:ACB_LSB+ACB_W],
                              pol[POL_W-1:2]};

   lcdt_pixdiv #(
      .DIV_W  (DIV_W),
      .TFT_MIN(TFT_DIV_MIN),
      .PAS_MIN(PAS_DIV_MIN)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (running),
      .tft      (tft_mode),
      .div_field(div_field),
      .stb      (pix_stb)
   );

   lcdt_axis u_hax (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (running),
      .step (pix_stb),
      .len  (h_len),
      .phase(h_phase),
      .wrap (h_wrap)
   );

   lcdt_axis u_vax (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (running),
      .step (h_wrap),
      .len  (v_len),
      .phase(v_phase),
      .wrap (frame_end)
   );

   lcdt_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .frame_end (frame_end),
      .starve_evt(pv_raw && pix_empty),
      .lost_evt  (sync_err),
      .running   (running),
      .done      (frame_done),
      .fuf       (underflow),
      .lost      (sync_lost)
   );

   assign hs_act = running && (h_phase == PH_SYNC);
   assign vs_act = running && (v_phase == PH_SYNC);
   assign de_raw = running && (h_phase == PH_ACT) && (v_phase == PH_ACT);
   assign pv_raw = de_raw && pix_stb;
   assign hs_pin = hs_act ~^ pol[POL_HS];
   assign vs_pin = vs_act ~^ pol[POL_VS];

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pix_tick  <= 1'b0;
               hsync     <= 1'b1;
               vsync     <= 1'b1;
               de        <= 1'b0;
               pix_valid <= 1'b0;
            end else begin
               pix_tick  <= pix_stb;
               hsync     <= hs_pin;
               vsync     <= vs_pin;
               de        <= de_raw;
               pix_valid <= pv_raw;
            end
         end
      end else begin : g_out_comb
         assign pix_tick  = pix_stb;
         assign hsync     = rst_n ? hs_pin : 1'b1;
         assign vsync     = rst_n ? vs_pin : 1'b1;
         assign de        = de_raw;
         assign pix_valid = pv_raw;
      end
   endgenerate

   logic [ACB_W-1:0] ab_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ab_cnt  <= '0;
         ac_bias <= 1'b0;
      end else if (!running || tft_mode) begin
         ab_cnt  <= '0;
         ac_bias <= 1'b0;
      end else if (h_wrap) begin
         if (ab_cnt == acb_field) begin
            ab_cnt  <= '0;
            ac_bias <= ~ac_bias;
         end else begin
            ab_cnt  <= ab_cnt + ACB_W'(1);
         end
      end
   end
endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic running,
   input logic frame_end,
   input logic pix_stb,
   input logic done,
   input logic fuf,
   input logic lost
);
   AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      pix_stb |=> !pix_stb);                                           // R3
   AST_FRAME_END_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> pix_stb);                                          // R2
   AST_RUN_TO_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !enable && !frame_end) |=> running);                 // R6
   AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !enable) |=> done);                                     // R7
   AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !running) |=> (running && !done));                    // R7
   AST_UNDERFLOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !fuf);                                               // R8
   AST_LOST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !lost);                                              // R9
endmodule

bind lcd_raster_timer lcdt_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .running  (running),
   .frame_end(frame_end),
   .pix_stb  (pix_stb),
   .done     (frame_done),
   .fuf      (underflow),
   .lost     (sync_lost)
);

// File: tb/lcd_raster_timer_bench.sv
module lcd_raster_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n, enable, tft_mode, pix_empty, sync_err;
   logic [31:0] horiz_cfg, vert_cfg, clock_cfg;
   logic        pix_tick, hsync, vsync, de, pix_valid, ac_bias;
   logic        frame_done, underflow, sync_lost;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   lcd_raster_timer u_lcd_raster_timer (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tft_mode(tft_mode),
      .horiz_cfg(horiz_cfg), .vert_cfg(vert_cfg), .clock_cfg(clock_cfg),
      .pix_empty(pix_empty), .sync_err(sync_err),
      .pix_tick(pix_tick), .hsync(hsync), .vsync(vsync), .de(de),
      .pix_valid(pix_valid), .ac_bias(ac_bias), .frame_done(frame_done),
      .underflow(underflow), .sync_lost(sync_lost)
   );

   // tft, div, hpix, hsw, hbp, hfp, vlines, vsw, vbp, vfp
   localparam int NV = 5;
   localparam int VEC [NV][10] = '{
      '{1, 2, 4, 1, 1, 1, 3, 1, 1, 1},
      '{1, 0, 6, 2, 2, 3, 4, 2, 0, 0},
      '{0, 1, 4, 1, 2, 1, 3, 1, 2, 1},
      '{1, 5, 3, 3, 1, 2, 2, 1, 1, 0},
      '{0, 4, 5, 1, 1, 1, 3, 2, 0, 2}
   };

   int m_frame, m_de, m_pv, m_hs, m_vs;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic apply_row(input int r, input int acb, input int pol);
      tft_mode  = VEC[r][0][0];
      horiz_cfg = 32'((VEC[r][2] - 1) | ((VEC[r][3] - 1) << 10) |
                      ((VEC[r][5] - 1) << 16) | ((VEC[r][4] - 1) << 24));
      vert_cfg  = 32'((VEC[r][6] - 1) | ((VEC[r][7] - 1) << 10) |
                      (VEC[r][9] << 16) | (VEC[r][8] << 24));
      clock_cfg = 32'(VEC[r][1] | (acb << 8) | (pol << 20));
   endtask

   function automatic int eff_div(input int r);
      int lo;
      lo = (VEC[r][0] != 0) ? 2 : 3;
      return (VEC[r][1] < lo) ? lo : VEC[r][1];
   endfunction

   task automatic wait_vs_edge();
      logic prev;
      prev = vsync;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (prev && !vsync) return;
         prev = vsync;
      end
   endtask

   task automatic measure_frame();
      logic prev;
      m_frame = 0; m_de = 0; m_pv = 0; m_hs = 0; m_vs = 0;
      prev = vsync;
      for (int i = 0; i < 20000; i++) begin
         m_frame++;
         m_de += int'(de);
         m_pv += int'(pix_valid);
         m_hs += int'(!hsync);
         m_vs += int'(!vsync);
         @(negedge clk);
         if (prev && !vsync) break;
         prev = vsync;
      end
   endtask

   task automatic stop_and_wait();
      enable = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (frame_done) break;
      end
   endtask

   initial begin
      int d, line, lines, cnt, t;
      logic prev;
      rst_n = 1'b0; enable = 1'b0; pix_empty = 1'b0; sync_err = 1'b0;
      apply_row(0, 0, 0);
      wait_cyc(4);
      // R11 reset state
      chk("R11 hsync", hsync, 1);
      chk("R11 vsync", vsync, 1);
      chk("R11 de", de, 0);
      chk("R11 pix_valid", pix_valid, 0);
      chk("R11 frame_done", frame_done, 0);
      chk("R11 flags", {underflow, sync_lost, ac_bias}, 0);
      rst_n = 1'b1;
      wait_cyc(2);

      // vector table: R1 R2 R3 R4 per row
      for (int r = 0; r < NV; r++) begin
         apply_row(r, 0, 0);
         wait_cyc(2);
         enable = 1'b1;
         wait_vs_edge();
         measure_frame();
         d     = eff_div(r);
         line  = d * (VEC[r][3] + VEC[r][4] + VEC[r][2] + VEC[r][5]);
         lines = VEC[r][7] + VEC[r][8] + VEC[r][6] + VEC[r][9];
         chk($sformatf("R3 row%0d frame cycles", r), m_frame, line * lines);
         chk($sformatf("R1 row%0d hsync cycles", r), m_hs, d * VEC[r][3] * lines);
         chk($sformatf("R2 row%0d vsync cycles", r), m_vs, VEC[r][7] * line);
         chk($sformatf("R4 row%0d de cycles", r), m_de, d * VEC[r][2] * VEC[r][6]);
         chk($sformatf("R4 row%0d pix_valid pulses", r), m_pv, VEC[r][2] * VEC[r][6]);
         stop_and_wait();
         chk($sformatf("R6 row%0d done after stop", r), frame_done, 1);
      end

      // R5 inverted polarity, idle and running
      apply_row(0, 0, 3);
      wait_cyc(3);
      chk("R5 idle hsync inverted", hsync, 0);
      chk("R5 idle vsync inverted", vsync, 0);
      enable = 1'b1;
      wait_cyc(5);
      cnt = 0;
      for (int i = 0; i < 84; i++) begin
         cnt += int'(hsync);
         @(negedge clk);
      end
      chk("R5 hsync active-high cycles", cnt, 12);
      stop_and_wait();

      // R6 R7 finish-frame stop (row0 frame = 84 clocks)
      apply_row(0, 0, 0);
      wait_cyc(2);
      enable = 1'b1;
      wait_vs_edge();
      wait_cyc(10);
      enable = 1'b0;
      cnt = 0;
      for (int i = 0; i < 70; i++) begin
         @(negedge clk);
         cnt += int'(de);
      end
      chk("R6 output continues after disable", int'(cnt > 0), 1);
      chk("R6 done not early", frame_done, 0);
      wait_cyc(8);
      chk("R6 done at frame end", frame_done, 1);
      cnt = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         cnt += int'(de || !hsync || !vsync || pix_valid);
      end
      chk("R6 idle after done", cnt, 0);
      chk("R7 done holds", frame_done, 1);
      enable = 1'b1;
      wait_cyc(3);
      chk("R7 done cleared on enable", frame_done, 0);

      // R8 underflow
      pix_empty = 1'b1;
      wait_cyc(100);
      chk("R8 underflow set", underflow, 1);
      pix_empty = 1'b0;
      wait_cyc(20);
      chk("R8 underflow holds", underflow, 1);
      enable = 1'b0;
      wait_cyc(2);
      chk("R8 underflow cleared by disable", underflow, 0);
      stop_and_wait();

      // R9 sync lost
      sync_err = 1'b1;
      wait_cyc(1);
      sync_err = 1'b0;
      wait_cyc(2);
      chk("R9 sync_err ignored when idle", sync_lost, 0);
      enable = 1'b1;
      wait_cyc(5);
      sync_err = 1'b1;
      wait_cyc(1);
      sync_err = 1'b0;
      wait_cyc(1);
      chk("R9 sync_lost set", sync_lost, 1);
      wait_cyc(20);
      chk("R9 sync_lost holds", sync_lost, 1);
      enable = 1'b0;
      wait_cyc(2);
      chk("R9 sync_lost cleared by disable", sync_lost, 0);
      stop_and_wait();

      // R10 passive ac bias, N=1: toggles every 2 lines of 24 clocks
      apply_row(2, 1, 0);
      wait_cyc(2);
      enable = 1'b1;
      prev = ac_bias;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (ac_bias != prev) break;
      end
      prev = ac_bias;
      t = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         t++;
         if (ac_bias != prev) break;
      end
      chk("R10 passive toggle period", t, 48);
      stop_and_wait();
      apply_row(0, 1, 0);
      wait_cyc(2);
      enable = 1'b1;
      cnt = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         cnt += int'(ac_bias);
      end
      chk("R10 tft ac_bias low", cnt, 0);
      stop_and_wait();

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule